// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load strobe captures a full starting address; each advance strobe then steps the two lowest address bits to the next beat while the upper bits stay exactly as loaded. The two low bits never carry into the upper bits, so a burst always stays inside its aligned group of four words.

A static order-select input picks the beat ordering. In linear order the low bits count up from the start value and wrap modulo four. In interleaved order the low bits are the start value XORed with the beat number. A clock-enable input freezes all state: while it is low, every strobe is ignored and the output address holds.

The output address is registered. It takes its new value on the same clock edge that accepts the load or advance.

Top module: `bseq_burst_addr`

## Requirements
- R1: While `rst` is high at a clock edge, `cur_addr` becomes 0.
- R2: An enabled edge with `load`=1 makes `cur_addr` equal to `start_addr` after that edge, and the beat count restarts at zero.
- R3: With `order_sel`=0 (linear), successive enabled advances after a load with start low bits s give low bits (s+1) mod 4, (s+2) mod 4, (s+3) mod 4.
- R4: With `order_sel`=1 (interleaved), successive enabled advances after a load with start low bits s give low bits s^1, s^2, s^3.
- R5: The fourth advance after a load returns the low bits to s. Bits [AW-1:2] of `cur_addr` never change except on a load.
- R6: While `clk_en`=0, `load` and `advance` are ignored and `cur_addr` holds its value.
- R7: When `load` and `advance` are both high on an enabled edge, the load wins and `cur_addr` equals `start_addr`.
- R8: An enabled edge with neither `load` nor `advance`, under an unchanged `order_sel`, leaves `cur_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Active-high clock enable; low freezes all state |
| load | input | 1 | Capture `start_addr` and restart the burst |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear wrap, 1 = XOR interleave |
| start_addr | input | AW | Burst start address |
| cur_addr | output | AW | Registered current beat address |

## Verification
A corrupted beat counter shows on the low two bits of `cur_addr` on the first edge after the advance that uses it. The error then stays visible as an offset on every later beat until the next load. A bad start register shows at once as wrong upper bits, or as a low sequence that does not return to the start after four advances. A clock-enable path that leaks shows as `cur_addr` changing on a frozen edge. For these reasons the bench compares the whole address after every single edge for every start value, in both orders.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          restart,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx
);
  always_comb begin
    cnt_nx = cnt;
    if (en) begin
      if (restart)   cnt_nx = '0;
      else if (step) cnt_nx = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    en && step && !restart |=> cnt == $past(cnt) + CW'(1));

  // R7
  restart_prio_chk: assert property (@(posedge clk) disable iff (rst)
    en && restart |=> cnt == '0);
endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] base_nx
);
  assign base_nx = (en && load) ? start_addr : base;

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else     base <= base_nx;
  end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
  parameter int CW = 2
) (
  input  bseq_pkg::order_e order,
  input  logic [CW-1:0]    start_lo,
  input  logic [CW-1:0]    beat,
  output logic [CW-1:0]    addr_lo
);
  logic [CW-1:0] lin_lo;
  logic [CW-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar i = 0; i < CW; i++) begin : g_xor
    assign xor_lo[i] = start_lo[i] ^ beat[i];
  end

  assign addr_lo = (order == bseq_pkg::ORD_XOR) ? xor_lo : lin_lo;
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr #(
  parameter int AW    = 8,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          load,
  input  logic          advance,
  input  logic          order_sel,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int CW = $clog2(BEATS);

  logic [AW-1:0] base, base_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [CW-1:0] lo_nx;
  bseq_pkg::order_e order;

  assign order = bseq_pkg::order_e'(order_sel);

  bseq_start_reg #(.AW(AW)) u_start (
    .clk(clk), .rst(rst), .en(clk_en), .load(load),
    .start_addr(start_addr), .base(base), .base_nx(base_nx)
  );

  bseq_beat_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .en(clk_en), .restart(load),
    .step(advance), .cnt(cnt), .cnt_nx(cnt_nx)
  );

  bseq_order_map #(.CW(CW)) u_map (
    .order(order), .start_lo(base_nx[CW-1:0]), .beat(cnt_nx), .addr_lo(lo_nx)
  );

  always_ff @(posedge clk) begin
    if (rst)         cur_addr <= '0;
    else if (clk_en) cur_addr <= {base_nx[AW-1:CW], lo_nx};
  end

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(cur_addr));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en && load |=> cur_addr == $past(start_addr));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !(clk_en && load) |=> cur_addr[AW-1:CW] == $past(cur_addr[AW-1:CW]));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> cur_addr == '0);

  // internal consistency: stored start matches output upper bits
  base_upper_chk: assert property (@(posedge clk) disable iff (rst)
    cur_addr[AW-1:CW] == base[AW-1:CW]);

  // counter is zero right after a load
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en && load |=> cnt == '0);
endmodule

// File: tb/bseq_burst_addr_test.sv
module bseq_burst_addr_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          load = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] cur_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bseq_burst_addr #(.AW(AW), .BEATS(4)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load(load), .advance(advance),
    .order_sel(order_sel), .start_addr(start_addr), .cur_addr(cur_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (cur_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, cur_addr, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic ld, input logic adv,
                     input logic [AW-1:0] sa);
    @(negedge clk);
    clk_en = en; load = ld; advance = adv; start_addr = sa;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s,
                                              input int k, input logic m);
    logic [1:0] lo;
    if (m) lo = s[1:0] ^ 2'(k % 4);
    else   lo = 2'((int'(s[1:0]) + k) % 4);
    return {s[AW-1:2], lo};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0);
    @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep: every start, both orders, five advances
    for (int m = 0; m < 2; m++) begin
      order_sel = 1'(m);
      for (int s = 0; s < (1 << AW); s++) begin
        cyc(1'b1, 1'b1, 1'b0, AW'(s));
        check("R2", AW'(s));
        for (int k = 1; k <= 5; k++) begin
          cyc(1'b1, 1'b0, 1'b1, '0);
          if (k == 4 || k == 5) check("R5", beat_addr(AW'(s), k, 1'(m)));
          else if (m == 1)      check("R4", beat_addr(AW'(s), k, 1'b1));
          else                  check("R3", beat_addr(AW'(s), k, 1'b0));
        end
      end
    end

    // R6: frozen clock enable ignores load and advance
    order_sel = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 8'hA5);
    check("R2", 8'hA5);
    cyc(1'b0, 1'b1, 1'b0, 8'h3C);
    check("R6", 8'hA5);
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    check("R6", 8'hA5);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R6", 8'hA6);

    // R8: idle enabled edges hold
    cyc(1'b1, 1'b0, 1'b0, 8'hFF);
    check("R8", 8'hA6);
    cyc(1'b1, 1'b0, 1'b0, 8'h11);
    check("R8", 8'hA6);

    // R7: load beats advance, beat restarts
    cyc(1'b1, 1'b1, 1'b1, 8'h7E);
    check("R7", 8'h7E);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R7", 8'h7F);

    // R4 mid-burst load in interleaved order
    order_sel = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 8'h42);
    check("R7", 8'h42);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R4", 8'h43);
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    check("R6", 8'h43);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R4", 8'h40);

    // R1 again: reset mid-burst
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule